// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small load/store processor that completes one instruction per clock. Each cycle it presents the program counter on an instruction fetch port and decodes the returned 32-bit word. It reads up to two operands from a 32-entry register file and computes a result or an effective address in an ALU. A load or store goes through a byte-enabled data port in the same cycle. The result is written back at the clock edge, and the program counter steps to the next word.

The instruction subset covers register-to-register add, subtract, OR, XOR and NOR, and left and right shifts by a constant amount. It also has add, AND and OR with a 16-bit immediate, a load of the upper half from an immediate, and loads and stores of bytes, halfwords and words. Both memories are outside the block. They are expected to return read data combinationally and to take a write at the rising clock edge. Memory order is little-endian. Control transfer, multiply and divide are not part of the subset, and any encoding outside the subset is treated as a no-op.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0 and dmem_we_o is 0. The first instruction executed after release is the one at address 0.
- R2: On every rising clock edge out of reset, imem_addr_o increases by 4.
- R3: With bits [31:26] = 0x00, func bits [5:0] 0x21, 0x23, 0x25, 0x26 and 0x27 write rs+rt, rs-rt, rs|rt, rs^rt and ~(rs|rt) to rd. The fields are rs [25:21], rt [20:16] and rd [15:11], and sum and difference wrap modulo 2^32.
- R4: With bits [31:26] = 0x00, func 0x00, 0x02 and 0x03 write to rd the value of rt shifted by shamt [10:6]: left, right with zero fill, or right with sign fill.
- R5: Opcode 0x09 adds the sign-extended immediate [15:0] to rs. Opcode 0x0C ANDs rs with the zero-extended immediate. Opcode 0x0D ORs rs with the zero-extended immediate. Opcode 0x0F writes the immediate shifted left by 16. All four write to rt.
- R6: Opcodes 0x20 and 0x24 load a sign- or zero-extended byte from lane addr[1:0], where lane k is data bits [8k+7:8k]. Opcodes 0x21 and 0x25 load a sign- or zero-extended halfword from the upper half when addr[1]=1 and the lower half otherwise. Opcode 0x23 loads the word. All loads write to rt.
- R7: Opcodes 0x28, 0x29 and 0x2B store the low byte, low halfword or whole word of rt. dmem_be_o bit k enables lane k: one lane for a byte, lanes 3:2 or 1:0 by addr[1] for a halfword, and all four for a word. Only enabled lanes change.
- R8: The load/store address on dmem_addr_o is rs plus the sign-extended 16-bit offset. The offset may be negative.
- R9: Register 0 reads as zero and is never changed by any write.
- R10: An opcode, or a func code under opcode 0x00, that is outside R3 to R7 writes no register and raises no memory write.
- R11: A register written by one instruction holds the new value for the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Instruction fetch byte address (program counter) |
| imem_data_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Data byte address |
| dmem_wdata_o | output | 32 | Store data, placed in the enabled lanes |
| dmem_be_o | output | 4 | Per-byte write enables |
| dmem_we_o | output | 1 | Data write strobe |
| dmem_rdata_i | input | 32 | Data word read at dmem_addr_o |

## Verification
The register-register ALU operations are tried on two operands whose high bits are set and whose sum carries out. This separates add from subtract, OR from XOR and NOR, and wrap-around from saturation. Shifts use a value with the top bit set, so that zero fill and sign fill differ, plus the shift amounts 0 and 31. Loads read one word with bytes of both signs, and this shows whether the sign or zero extension and the byte lane are right. Stores write into words already filled with known bytes, so any wrong lane, and any write from a register-0 destination or an undefined encoding, shows in memory.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;
  localparam int SHW    = $clog2(XLEN);
  localparam int NLANE  = XLEN / 8;

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_ADDIU = 6'h09;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LB    = 6'h20;
  localparam logic [5:0] OP_LH    = 6'h21;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_LBU   = 6'h24;
  localparam logic [5:0] OP_LHU   = 6'h25;
  localparam logic [5:0] OP_SB    = 6'h28;
  localparam logic [5:0] OP_SH    = 6'h29;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W} mem_size_e;

  typedef struct packed {
    alu_op_e           alu_op;
    logic              b_imm;
    logic [XLEN-1:0]   imm;
    logic              rf_we;
    logic [REG_AW-1:0] wr_addr;
    logic              mem_rd;
    logic              mem_wr;
    mem_size_e         size;
    logic              ld_signed;
    logic              illegal;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0]        op_i,
  input  logic [REG_AW-1:0] rt_i,
  input  logic [15:0]       imm_i,
  output ctrl_t             ctrl_o
);
  logic [5:0]        func;
  logic [REG_AW-1:0] rd;
  logic [XLEN-1:0]   sext, zext;

  assign func = imm_i[5:0];
  assign rd   = imm_i[15:11];
  assign sext = {{(XLEN-16){imm_i[15]}}, imm_i};
  assign zext = {{(XLEN-16){1'b0}}, imm_i};

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.alu_op  = ALU_ADD;
    ctrl_o.size    = SZ_W;
    ctrl_o.wr_addr = rt_i;
    ctrl_o.imm     = sext;
    unique case (op_i)
      OP_REG: begin
        ctrl_o.wr_addr = rd;
        ctrl_o.rf_we   = 1'b1;
        case (func)
          FN_ADDU: ctrl_o.alu_op = ALU_ADD;
          FN_SUBU: ctrl_o.alu_op = ALU_SUB;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_XOR:  ctrl_o.alu_op = ALU_XOR;
          FN_NOR:  ctrl_o.alu_op = ALU_NOR;
          FN_SLL:  ctrl_o.alu_op = ALU_SLL;
          FN_SRL:  ctrl_o.alu_op = ALU_SRL;
          FN_SRA:  ctrl_o.alu_op = ALU_SRA;
          default: begin
            ctrl_o.rf_we   = 1'b0;
            ctrl_o.illegal = 1'b1;
          end
        endcase
      end
      OP_ADDIU: begin ctrl_o.b_imm = 1'b1; ctrl_o.rf_we = 1'b1; end
      OP_ANDI: begin
        ctrl_o.b_imm = 1'b1; ctrl_o.rf_we = 1'b1;
        ctrl_o.imm = zext; ctrl_o.alu_op = ALU_AND;
      end
      OP_ORI: begin
        ctrl_o.b_imm = 1'b1; ctrl_o.rf_we = 1'b1;
        ctrl_o.imm = zext; ctrl_o.alu_op = ALU_OR;
      end
      OP_LUI: begin
        ctrl_o.b_imm = 1'b1; ctrl_o.rf_we = 1'b1;
        ctrl_o.imm = {imm_i, {(XLEN-16){1'b0}}}; ctrl_o.alu_op = ALU_PASSB;
      end
      OP_LB, OP_LBU, OP_LH, OP_LHU, OP_LW: begin
        ctrl_o.b_imm     = 1'b1;
        ctrl_o.rf_we     = 1'b1;
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.ld_signed = (op_i == OP_LB) || (op_i == OP_LH);
        ctrl_o.size      = (op_i == OP_LW) ? SZ_W :
                           (op_i == OP_LH || op_i == OP_LHU) ? SZ_H : SZ_B;
      end
      OP_SB, OP_SH, OP_SW: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.mem_wr = 1'b1;
        ctrl_o.size   = (op_i == OP_SW) ? SZ_W : (op_i == OP_SH) ? SZ_H : SZ_B;
      end
      default: ctrl_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [SHW-1:0]  shamt_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD:   y_o = a_i + b_i;
      ALU_SUB:   y_o = a_i - b_i;
      ALU_AND:   y_o = a_i & b_i;
      ALU_OR:    y_o = a_i | b_i;
      ALU_XOR:   y_o = a_i ^ b_i;
      ALU_NOR:   y_o = ~(a_i | b_i);
      ALU_SLL:   y_o = b_i << shamt_i;
      ALU_SRL:   y_o = b_i >> shamt_i;
      ALU_SRA:   y_o = $unsigned($signed(b_i) >>> shamt_i);
      ALU_PASSB: y_o = b_i;
      default:   y_o = '0;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] ra_i,
  input  logic [REG_AW-1:0] rb_i,
  output logic [XLEN-1:0]   qa_o,
  output logic [XLEN-1:0]   qb_o,
  input  logic              we_i,
  input  logic [REG_AW-1:0] wa_i,
  input  logic [XLEN-1:0]   wd_i
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign qa_o = (ra_i == '0) ? '0 : regs_q[ra_i];
  assign qb_o = (rb_i == '0) ? '0 : regs_q[rb_i];

  // R9: storage of register 0 stays zero whatever is written
  assert_r0_store_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i == '0) |=> (regs_q[0] == '0));
endmodule

// File: rtl/sc_lsu.sv
module sc_lsu
  import sc_pkg::*;
(
  input  logic [1:0]       addr_lo_i,
  input  mem_size_e        size_i,
  input  logic             ld_signed_i,
  input  logic             wr_en_i,
  input  logic [XLEN-1:0]  st_data_i,
  input  logic [XLEN-1:0]  rdata_i,
  output logic [XLEN-1:0]  wdata_o,
  output logic [NLANE-1:0] be_o,
  output logic [XLEN-1:0]  ld_data_o
);
  logic [XLEN-1:0] lane;
  logic [15:0]     half;

  assign lane = rdata_i >> {addr_lo_i, 3'b000};
  assign half = addr_lo_i[1] ? rdata_i[31:16] : rdata_i[15:0];

  always_comb begin
    unique case (size_i)
      SZ_B: begin
        wdata_o = {NLANE{st_data_i[7:0]}};
        be_o    = NLANE'(1) << addr_lo_i;
      end
      SZ_H: begin
        wdata_o = {(NLANE/2){st_data_i[15:0]}};
        be_o    = addr_lo_i[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        wdata_o = st_data_i;
        be_o    = '1;
      end
    endcase
    if (!wr_en_i) be_o = '0;
  end

  always_comb begin
    unique case (size_i)
      SZ_B:    ld_data_o = {{(XLEN-8){ld_signed_i & lane[7]}}, lane[7:0]};
      SZ_H:    ld_data_o = {{(XLEN-16){ld_signed_i & half[15]}}, half};
      default: ld_data_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [XLEN-1:0]  imem_addr_o,
  input  logic [XLEN-1:0]  imem_data_i,
  output logic [XLEN-1:0]  dmem_addr_o,
  output logic [XLEN-1:0]  dmem_wdata_o,
  output logic [NLANE-1:0] dmem_be_o,
  output logic             dmem_we_o,
  input  logic [XLEN-1:0]  dmem_rdata_i
);
  logic [XLEN-1:0] pc_q;
  ctrl_t           ctrl;
  logic [XLEN-1:0] rs_val, rt_val, op_b, alu_y, ld_data, wb_data;
  logic            st_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_q + XLEN'(4);
  end
  assign imem_addr_o = pc_q;

  sc_decode u_decode (
    .op_i  (imem_data_i[31:26]),
    .rt_i  (imem_data_i[20:16]),
    .imm_i (imem_data_i[15:0]),
    .ctrl_o(ctrl)
  );

  sc_regfile u_regfile (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_i  (imem_data_i[25:21]),
    .rb_i  (imem_data_i[20:16]),
    .qa_o  (rs_val),
    .qb_o  (rt_val),
    .we_i  (ctrl.rf_we),
    .wa_i  (ctrl.wr_addr),
    .wd_i  (wb_data)
  );

  assign op_b = ctrl.b_imm ? ctrl.imm : rt_val;

  sc_alu u_alu (
    .op_i   (ctrl.alu_op),
    .a_i    (rs_val),
    .b_i    (op_b),
    .shamt_i(imem_data_i[10:6]),
    .y_o    (alu_y)
  );

  assign st_en = ctrl.mem_wr & rst_ni;

  sc_lsu u_lsu (
    .addr_lo_i  (alu_y[1:0]),
    .size_i     (ctrl.size),
    .ld_signed_i(ctrl.ld_signed),
    .wr_en_i    (st_en),
    .st_data_i  (rt_val),
    .rdata_i    (dmem_rdata_i),
    .wdata_o    (dmem_wdata_o),
    .be_o       (dmem_be_o),
    .ld_data_o  (ld_data)
  );

  assign wb_data     = ctrl.mem_rd ? ld_data : alu_y;
  assign dmem_addr_o = alu_y;
  assign dmem_we_o   = st_en;

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !dmem_we_o);

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (imem_addr_o == $past(imem_addr_o) + XLEN'(4)));

  assert_sext_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.mem_rd && ctrl.size == SZ_B && ctrl.ld_signed)
      |-> (wb_data[XLEN-1:8] == {(XLEN-8){wb_data[7]}}));

  assert_byte_lane_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_we_o && ctrl.size == SZ_B) |-> ($countones(dmem_be_o) == 1));

  assert_src_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imem_data_i[25:21] == '0) |-> (rs_val == '0));

  assert_undef_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.illegal |-> (!dmem_we_o && dmem_be_o == '0 && !ctrl.rf_we));
endmodule

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic [3:0]  dmem_be;
  logic        dmem_we;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  int          plen;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  assign imem_data  = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) begin
    if (dmem_we)
      for (int k = 0; k < 4; k++)
        if (dmem_be[k]) dmem[dmem_addr[9:2]][8*k +: 8] <= dmem_wdata[8*k +: 8];
  end

  sc_core dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .imem_addr_o (imem_addr),
    .imem_data_i (imem_data),
    .dmem_addr_o (dmem_addr),
    .dmem_wdata_o(dmem_wdata),
    .dmem_be_o   (dmem_be),
    .dmem_we_o   (dmem_we),
    .dmem_rdata_i(dmem_rdata)
  );

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd,
                                        input logic [4:0] sh);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < 256; i++) begin imem[i] = '0; dmem[i] = '0; end
    plen = 0;
  endtask

  task automatic emit(input logic [31:0] ins);
    imem[plen] = ins;
    plen++;
  endtask

  task automatic run_prog();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (plen + 1) @(negedge clk);
  endtask

  // lui+ori pair builds a 32-bit constant (R5, R11)
  task automatic load_const(input logic [4:0] r, input logic [31:0] v);
    emit(enc_i(6'h0F, 5'd0, r, v[31:16]));
    emit(enc_i(6'h0D, r, r, v[15:0]));
  endtask

  task automatic t_reset();
    clear_all();
    emit(enc_i(6'h2B, 5'd0, 5'd0, 16'd0));
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 pc in reset", imem_addr, 32'd0);
    check("R1 we in reset", {31'd0, dmem_we}, 32'd0);
    rst_n = 1'b1; #1;
    check("R1 first fetch", imem_addr, 32'd0);
    check("R1 store after release", {31'd0, dmem_we}, 32'd1);
    @(negedge clk);
    check("R2 pc step 1", imem_addr, 32'd4);
    @(negedge clk);
    check("R2 pc step 2", imem_addr, 32'd8);
  endtask

  task automatic t_regreg();
    logic [31:0] a = 32'h1234_5678, b = 32'hF0F0_0FF0;
    clear_all();
    load_const(5'd1, a);
    load_const(5'd2, b);
    emit(enc_r(6'h21, 5'd1, 5'd2, 5'd3, 5'd0));
    emit(enc_r(6'h23, 5'd1, 5'd2, 5'd4, 5'd0));
    emit(enc_r(6'h25, 5'd1, 5'd2, 5'd5, 5'd0));
    emit(enc_r(6'h26, 5'd1, 5'd2, 5'd6, 5'd0));
    emit(enc_r(6'h27, 5'd1, 5'd2, 5'd7, 5'd0));
    for (int k = 3; k <= 7; k++) emit(enc_i(6'h2B, 5'd0, 5'(k), 16'(4 * k)));
    run_prog();
    check("R3 add wrap", dmem[3], a + b);
    check("R3 sub", dmem[4], a - b);
    check("R3 or", dmem[5], a | b);
    check("R3 xor", dmem[6], a ^ b);
    check("R3 nor", dmem[7], ~(a | b));
  endtask

  task automatic t_shift();
    clear_all();
    load_const(5'd1, 32'h8000_0F01);
    emit(enc_r(6'h00, 5'd0, 5'd1, 5'd2, 5'd4));
    emit(enc_r(6'h02, 5'd0, 5'd1, 5'd3, 5'd4));
    emit(enc_r(6'h03, 5'd0, 5'd1, 5'd4, 5'd4));
    emit(enc_r(6'h00, 5'd0, 5'd1, 5'd5, 5'd0));
    emit(enc_r(6'h03, 5'd0, 5'd1, 5'd6, 5'd31));
    for (int k = 2; k <= 6; k++) emit(enc_i(6'h2B, 5'd0, 5'(k), 16'(120 + 4 * k)));
    run_prog();
    check("R4 sll 4", dmem[32], 32'h0000_F010);
    check("R4 srl 4", dmem[33], 32'h0800_00F0);
    check("R4 sra 4", dmem[34], 32'hF800_00F0);
    check("R4 sll 0", dmem[35], 32'h8000_0F01);
    check("R4 sra 31", dmem[36], 32'hFFFF_FFFF);
  endtask

  task automatic t_imm();
    clear_all();
    emit(enc_i(6'h09, 5'd0, 5'd1, 16'hFFFF));
    emit(enc_i(6'h09, 5'd1, 5'd2, 16'd5));
    emit(enc_i(6'h0C, 5'd1, 5'd3, 16'h8001));
    emit(enc_i(6'h0D, 5'd0, 5'd4, 16'h8000));
    emit(enc_i(6'h0F, 5'd0, 5'd5, 16'hABCD));
    emit(enc_i(6'h09, 5'd0, 5'd6, 16'h7FFF));
    for (int k = 1; k <= 6; k++) emit(enc_i(6'h2B, 5'd0, 5'(k), 16'(160 + 4 * k)));
    run_prog();
    check("R5 addiu sext", dmem[41], 32'hFFFF_FFFF);
    check("R5 R11 dependent add", dmem[42], 32'd4);
    check("R5 andi zext", dmem[43], 32'h0000_8001);
    check("R5 ori zext", dmem[44], 32'h0000_8000);
    check("R5 lui", dmem[45], 32'hABCD_0000);
    check("R5 addiu positive", dmem[46], 32'h0000_7FFF);
  endtask

  task automatic t_load();
    clear_all();
    dmem[4] = 32'h80F1_7F02;
    emit(enc_i(6'h09, 5'd0, 5'd9, 16'd16));
    emit(enc_i(6'h20, 5'd9, 5'd1, 16'd0));
    emit(enc_i(6'h20, 5'd9, 5'd2, 16'd3));
    emit(enc_i(6'h24, 5'd9, 5'd3, 16'd3));
    emit(enc_i(6'h21, 5'd9, 5'd4, 16'd2));
    emit(enc_i(6'h25, 5'd9, 5'd5, 16'd2));
    emit(enc_i(6'h21, 5'd9, 5'd6, 16'd0));
    emit(enc_i(6'h23, 5'd9, 5'd7, 16'd0));
    emit(enc_i(6'h09, 5'd0, 5'd10, 16'd20));
    emit(enc_i(6'h23, 5'd10, 5'd8, 16'hFFFC));
    emit(enc_i(6'h24, 5'd9, 5'd11, 16'd2));
    for (int k = 1; k <= 8; k++) emit(enc_i(6'h2B, 5'd0, 5'(k), 16'(28 + 4 * k)));
    emit(enc_i(6'h2B, 5'd0, 5'd11, 16'd64));
    run_prog();
    check("R6 lb lane0", dmem[8], 32'h0000_0002);
    check("R6 lb lane3 neg", dmem[9], 32'hFFFF_FF80);
    check("R6 lbu lane3", dmem[10], 32'h0000_0080);
    check("R6 lh upper neg", dmem[11], 32'hFFFF_80F1);
    check("R6 lhu upper", dmem[12], 32'h0000_80F1);
    check("R6 lh lower pos", dmem[13], 32'h0000_7F02);
    check("R6 lw", dmem[14], 32'h80F1_7F02);
    check("R8 negative offset load", dmem[15], 32'h80F1_7F02);
    check("R6 lbu lane2", dmem[16], 32'h0000_00F1);
  endtask

  task automatic t_store();
    clear_all();
    dmem[19] = 32'h0BAD_0BAD;
    dmem[20] = 32'h1122_3344;
    dmem[21] = 32'h5566_7788;
    dmem[22] = 32'h99AA_BBCC;
    dmem[23] = 32'h0102_0304;
    load_const(5'd1, 32'hAABB_CCDD);
    emit(enc_i(6'h09, 5'd0, 5'd9, 16'd80));
    emit(enc_i(6'h28, 5'd9, 5'd1, 16'd1));
    emit(enc_i(6'h29, 5'd9, 5'd1, 16'd6));
    emit(enc_i(6'h28, 5'd9, 5'd1, 16'd11));
    emit(enc_i(6'h29, 5'd9, 5'd1, 16'd12));
    emit(enc_i(6'h2B, 5'd9, 5'd1, 16'hFFFC));
    run_prog();
    check("R7 sb lane1", dmem[20], 32'h1122_DD44);
    check("R7 sh upper", dmem[21], 32'hCCDD_7788);
    check("R7 sb lane3", dmem[22], 32'hDDAA_BBCC);
    check("R7 sh lower", dmem[23], 32'h0102_CCDD);
    check("R8 negative offset store", dmem[19], 32'hAABB_CCDD);
  endtask

  task automatic t_r0_undef();
    clear_all();
    dmem[24] = 32'hDEAD_DEAD;
    dmem[25] = 32'hCAFE_F00D;
    dmem[26] = 32'h1234_5678;
    dmem[27] = 32'h7777_7777;
    emit(enc_i(6'h09, 5'd0, 5'd1, 16'd5));
    emit(enc_i(6'h3F, 5'd0, 5'd1, 16'h1234));
    emit(enc_r(6'h3F, 5'd1, 5'd1, 5'd1, 5'd0));
    emit(enc_r(6'h22, 5'd1, 5'd1, 5'd1, 5'd0));
    emit(enc_i(6'h2A, 5'd0, 5'd1, 16'd100));
    emit(enc_i(6'h2C, 5'd0, 5'd1, 16'd108));
    emit(enc_i(6'h09, 5'd0, 5'd0, 16'd7));
    emit(enc_i(6'h0F, 5'd0, 5'd0, 16'hFFFF));
    emit(enc_r(6'h25, 5'd1, 5'd1, 5'd0, 5'd0));
    emit(enc_i(6'h2B, 5'd0, 5'd1, 16'd96));
    emit(enc_i(6'h2B, 5'd0, 5'd0, 16'd104));
    run_prog();
    check("R10 no reg write on undefined", dmem[24], 32'd5);
    check("R10 no store on undefined op", dmem[25], 32'hCAFE_F00D);
    check("R10 no store on undefined op 2", dmem[27], 32'h7777_7777);
    check("R9 r0 stays zero", dmem[26], 32'd0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    clear_all();
    t_reset();
    t_regreg();
    t_shift();
    t_imm();
    t_load();
    t_store();
    t_r0_undef();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule